// File: doc/BRIEF.md
# ALU Status Flag Generator

A purely combinational integer ALU for the data-processing stage of a classic 32-bit RISC core, together with the logic that produces the next negative, zero, carry and overflow flags. It takes a 4-bit operation code, two operands, the current flag values and the carry-out from the operand shifter. It also takes a set-flags enable and the index of the destination register. It returns the result, a register write-enable, the next flag values, a request to copy the saved status word into the current status word, and an indication for an undefined test encoding.

Subtraction reports carry as "no borrow". The carrying subtract forms fold the inverted incoming carry into the subtrahend. Bitwise operations take their carry from the shifter and leave overflow alone. A flag-setting operation that targets the program counter register asks for a status restore and does not compute flags. The register file, the shifter and the processor-mode logic sit outside this block.

Top module: `alu_flag_gen`

## Requirements
- R1: The opcode values give these results: 0 is a AND b, 1 is a XOR b, 12 (0xC) is a OR b, 13 (0xD) is b, 14 (0xE) is a AND NOT b, and 15 (0xF) is NOT b. Opcodes 8 and 9 compute AND and XOR.
- R2: Opcode 4 (add) gives a+b and opcode 5 (add with carry) gives a+b+c_in. C is the carry out of the top bit, including a carry from adding c_in. V is set when both addends have the same sign and the result sign differs from it.
- R3: Opcode 2 gives a−b and opcode 3 gives b−a. C is 1 exactly when the subtrahend is not larger than the minuend. V is set on signed overflow of the difference.
- R4: Opcode 6 gives a−(b−c_in+1) and opcode 7 gives b−(a−c_in+1), with the subtrahend held in at least 33 bits. C is 1 exactly when that subtrahend is not larger than the minuend.
- R5: When a bitwise opcode (0, 1, 12–15) updates flags, C equals shift_carry and V keeps v_in.
- R6: With set_flags low, a non-test opcode holds all four flags at their input values and still asserts result_we.
- R7: The test opcodes 8, 9, 10 (compare, a−b) and 11 (compare negative, a+b) never assert result_we. When dest_idx is not 15 they update the flags whatever set_flags is. Opcodes 8 and 9 use the R5 rules for C and V, and opcodes 10 and 11 use the R3 and R2 rules.
- R8: A non-test opcode with set_flags high and dest_idx equal to 15 asserts result_we and restore_psr, and holds all four flags.
- R9: A test opcode with dest_idx equal to 15 asserts undef_op, deasserts result_we and restore_psr, and holds all four flags.
- R10: Whenever flags are updated, N equals bit 31 of result and Z is 1 exactly when the 32-bit result is zero. The result port carries the computed value for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand (register operand) |
| opnd_b | input | 32 | Second operand (shifter output) |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| shift_carry | input | 1 | Carry produced by the operand shifter |
| set_flags | input | 1 | Flag update enable for non-test opcodes |
| dest_idx | input | 4 | Destination register index |
| result | output | 32 | Computed value |
| result_we | output | 1 | Destination register write-enable |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |
| restore_psr | output | 1 | Copy saved status into current status |
| undef_op | output | 1 | Test opcode aimed at register 15 |

## Verification
The block holds no state, so every output is valid in the same cycle its inputs change, with zero registers on the path. The bench applies each input vector just after a falling clock edge. It compares all outputs one nanosecond after the next rising edge, so the outputs have settled and the inputs are still held. Expected values come from a bench-side model that uses wide integer arithmetic and sign comparisons. This model is checked against the directed corner values and against random operands.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0,
      OP_EOR = 4'h1,
      OP_SUB = 4'h2,
      OP_RSB = 4'h3,
      OP_ADD = 4'h4,
      OP_ADC = 4'h5,
      OP_SBC = 4'h6,
      OP_RSC = 4'h7,
      OP_TST = 4'h8,
      OP_TEQ = 4'h9,
      OP_CMP = 4'hA,
      OP_CMN = 4'hB,
      OP_ORR = 4'hC,
      OP_MOV = 4'hD,
      OP_BIC = 4'hE,
      OP_MVN = 4'hF
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   // test opcodes occupy 8..11
   function automatic logic op_is_test(input logic [3:0] op);
      return op[3:2] == 2'b10;
   endfunction

   // bitwise family: 0, 1, 8, 9, 12..15
   function automatic logic op_is_bitwise(input logic [3:0] op);
      return (op[3:1] == 3'b000) || (op[3:1] == 3'b100) || (op[3:2] == 2'b11);
   endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);
   import alu_flag_pkg::*;

   always_comb begin
      unique case (op)
         OP_AND, OP_TST: res = a & b;
         OP_EOR, OP_TEQ: res = a ^ b;
         OP_ORR:         res = a | b;
         OP_MOV:         res = b;
         OP_BIC:         res = a & ~b;
         OP_MVN:         res = ~b;
         default:        res = '0;
      endcase
   end

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
   parameter int DATA_W       = 32,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              carry_flag,
   output logic [DATA_W-1:0] res,
   output logic              carry_out,
   output logic              ovf_out
);
   import alu_flag_pkg::*;

   localparam int MSB = DATA_W - 1;

   logic              swap_ops;
   logic              negate_rhs;
   logic              cy_seed;
   logic [DATA_W-1:0] lhs;
   logic [DATA_W-1:0] rhs;
   logic [DATA_W-1:0] rhs_eff;
   logic [DATA_W-1:0] sum;
   logic              cy_top;

   always_comb begin
      swap_ops   = (op == OP_RSB) || (op == OP_RSC);
      negate_rhs = (op == OP_SUB) || (op == OP_RSB) || (op == OP_SBC) ||
                   (op == OP_RSC) || (op == OP_CMP);
      unique case (op)
         OP_SUB, OP_RSB, OP_CMP: cy_seed = 1'b1;
         OP_ADC, OP_SBC, OP_RSC: cy_seed = carry_flag;
         default:                cy_seed = 1'b0;
      endcase
      lhs     = swap_ops ? b : a;
      rhs     = swap_ops ? a : b;
      rhs_eff = negate_rhs ? ~rhs : rhs;
   end

   generate
      if (RIPPLE_ADDER) begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = cy_seed;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = lhs[i] ^ rhs_eff[i] ^ cy[i];
            assign cy[i+1] = (lhs[i] & rhs_eff[i]) | (cy[i] & (lhs[i] ^ rhs_eff[i]));
         end
         assign cy_top = cy[DATA_W];
      end else begin : g_wide
         logic [DATA_W:0] wide;
         assign wide   = {1'b0, lhs} + {1'b0, rhs_eff} + {{DATA_W{1'b0}}, cy_seed};
         assign sum    = wide[MSB:0];
         assign cy_top = wide[DATA_W];
      end
   endgenerate

   assign res       = sum;
   assign carry_out = cy_top;
   assign ovf_out   = (lhs[MSB] ^ sum[MSB]) & (rhs_eff[MSB] ^ sum[MSB]);

endmodule

// File: rtl/alu_flag_select.sv
module alu_flag_select #(
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 4,
   parameter int PC_IDX    = 15
) (
   input  logic [3:0]           op,
   input  logic                 set_flags,
   input  logic [REG_IDX_W-1:0] dest_idx,
   input  logic [DATA_W-1:0]    bit_res,
   input  logic [DATA_W-1:0]    sum_res,
   input  logic                 sum_carry,
   input  logic                 sum_ovf,
   input  logic                 shift_carry,
   input  alu_flag_pkg::nzcv_t  flags_in,
   output logic [DATA_W-1:0]    result,
   output logic                 result_we,
   output alu_flag_pkg::nzcv_t  flags_out,
   output logic                 restore_psr,
   output logic                 undef_op
);
   import alu_flag_pkg::*;

   localparam int MSB = DATA_W - 1;
   localparam logic [REG_IDX_W-1:0] PC_SEL = REG_IDX_W'(PC_IDX);

   logic is_test;
   logic is_bit;
   logic to_pc;
   logic update;

   always_comb begin
      is_test     = op_is_test(op);
      is_bit      = op_is_bitwise(op);
      to_pc       = (dest_idx == PC_SEL);
      result      = is_bit ? bit_res : sum_res;
      undef_op    = is_test && to_pc;
      restore_psr = set_flags && !is_test && to_pc;
      result_we   = !is_test;
      update      = is_test ? !to_pc : (set_flags && !to_pc);
      if (update) begin
         flags_out.n = result[MSB];
         flags_out.z = (result == '0);
         flags_out.c = is_bit ? shift_carry : sum_carry;
         flags_out.v = is_bit ? flags_in.v  : sum_ovf;
      end else begin
         flags_out = flags_in;
      end
   end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
   parameter int DATA_W       = 32,
   parameter int REG_IDX_W    = 4,
   parameter int PC_IDX       = 15,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic [3:0]           op_code,
   input  logic [DATA_W-1:0]    opnd_a,
   input  logic [DATA_W-1:0]    opnd_b,
   input  logic                 n_in,
   input  logic                 z_in,
   input  logic                 c_in,
   input  logic                 v_in,
   input  logic                 shift_carry,
   input  logic                 set_flags,
   input  logic [REG_IDX_W-1:0] dest_idx,
   output logic [DATA_W-1:0]    result,
   output logic                 result_we,
   output logic                 n_out,
   output logic                 z_out,
   output logic                 c_out,
   output logic                 v_out,
   output logic                 restore_psr,
   output logic                 undef_op
);
   import alu_flag_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("alu_flag_gen: DATA_W must be at least 2");
      end
      if (PC_IDX < 0 || PC_IDX >= (1 << REG_IDX_W)) begin : g_bad_pc
         $error("alu_flag_gen: PC_IDX does not fit in REG_IDX_W bits");
      end
   endgenerate

   logic [DATA_W-1:0] bit_res;
   logic [DATA_W-1:0] sum_res;
   logic              sum_carry;
   logic              sum_ovf;
   nzcv_t             flags_cur;
   nzcv_t             flags_nxt;

   assign flags_cur = '{n: n_in, z: z_in, c: c_in, v: v_in};

   alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .op  (op_code),
      .a   (opnd_a),
      .b   (opnd_b),
      .res (bit_res)
   );

   alu_arith_unit #(.DATA_W(DATA_W), .RIPPLE_ADDER(RIPPLE_ADDER)) u_arith (
      .op         (op_code),
      .a          (opnd_a),
      .b          (opnd_b),
      .carry_flag (c_in),
      .res        (sum_res),
      .carry_out  (sum_carry),
      .ovf_out    (sum_ovf)
   );

   alu_flag_select #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W), .PC_IDX(PC_IDX)) u_sel (
      .op          (op_code),
      .set_flags   (set_flags),
      .dest_idx    (dest_idx),
      .bit_res     (bit_res),
      .sum_res     (sum_res),
      .sum_carry   (sum_carry),
      .sum_ovf     (sum_ovf),
      .shift_carry (shift_carry),
      .flags_in    (flags_cur),
      .result      (result),
      .result_we   (result_we),
      .flags_out   (flags_nxt),
      .restore_psr (restore_psr),
      .undef_op    (undef_op)
   );

   assign n_out = flags_nxt.n;
   assign z_out = flags_nxt.z;
   assign c_out = flags_nxt.c;
   assign v_out = flags_nxt.v;

endmodule

// File: rtl/alu_flag_gen_chk.sv
module alu_flag_gen_chk #(
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 4
) (
   input logic [3:0]           op_code,
   input logic                 n_in,
   input logic                 z_in,
   input logic                 c_in,
   input logic                 v_in,
   input logic                 shift_carry,
   input logic                 set_flags,
   input logic [REG_IDX_W-1:0] dest_idx,
   input logic [DATA_W-1:0]    result,
   input logic                 result_we,
   input logic                 n_out,
   input logic                 z_out,
   input logic                 c_out,
   input logic                 v_out,
   input logic                 restore_psr,
   input logic                 undef_op
);
   logic test_op;
   logic bitwise_op;
   logic held;

   always_comb begin
      test_op    = (op_code[3:2] == 2'b10);
      bitwise_op = (op_code[3:1] == 3'b000) || (op_code[3:1] == 3'b100) ||
                   (op_code[3:2] == 2'b11);
      held       = (n_out == n_in) && (z_out == z_in) && (c_out == c_in) && (v_out == v_in);

      assert_test_no_write_R7: assert (!test_op || !result_we);
      assert_restore_holds_R8: assert (!restore_psr || (result_we && held && !undef_op));
      assert_undef_quiet_R9:   assert (!undef_op || (!result_we && !restore_psr && held));
      assert_noset_holds_R6:   assert (test_op || set_flags || held);
      if (!held) begin
         assert_nz_track_R10: assert ((n_out == result[DATA_W-1]) && (z_out == (result == '0)));
         assert_bit_cv_R5:    assert (!bitwise_op || (c_out == shift_carry && v_out == v_in));
      end
   end

endmodule

bind alu_flag_gen alu_flag_gen_chk #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_chk (
   .op_code     (op_code),
   .n_in        (n_in),
   .z_in        (z_in),
   .c_in        (c_in),
   .v_in        (v_in),
   .shift_carry (shift_carry),
   .set_flags   (set_flags),
   .dest_idx    (dest_idx),
   .result      (result),
   .result_we   (result_we),
   .n_out       (n_out),
   .z_out       (z_out),
   .c_out       (c_out),
   .v_out       (v_out),
   .restore_psr (restore_psr),
   .undef_op    (undef_op)
);

// File: tb/alu_flag_gen_test.sv
module alu_flag_gen_test;

   // out vector layout: {result[31:0], we, n, z, c, v, restore, undef}
   typedef logic [38:0] ovec_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op;
   logic [31:0] a, b;
   logic        nin, zin, cin, vin, shc, sf;
   logic [3:0]  dst;
   logic [31:0] result;
   logic        result_we, n_out, z_out, c_out, v_out, restore_psr, undef_op;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   alu_flag_gen uut (
      .op_code     (op),
      .opnd_a      (a),
      .opnd_b      (b),
      .n_in        (nin),
      .z_in        (zin),
      .c_in        (cin),
      .v_in        (vin),
      .shift_carry (shc),
      .set_flags   (sf),
      .dest_idx    (dst),
      .result      (result),
      .result_we   (result_we),
      .n_out       (n_out),
      .z_out       (z_out),
      .c_out       (c_out),
      .v_out       (v_out),
      .restore_psr (restore_psr),
      .undef_op    (undef_op)
   );

   function automatic ovec_t model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                                   input logic fn, input logic fz, input logic fc, input logic fv,
                                   input logic sh, input logic s, input logic [3:0] d);
      logic [31:0] l, r, res;
      logic        c, v, bitw, tst, we, rest, und, upd;
      longint unsigned sub;
      tst  = (o >= 4'h8 && o <= 4'hB);
      bitw = (o <= 4'h1) || o == 4'h8 || o == 4'h9 || o >= 4'hC;
      l = ((o == 4'h3) || (o == 4'h7)) ? y : x;
      r = ((o == 4'h3) || (o == 4'h7)) ? x : y;
      c = 1'b0; v = 1'b0; res = '0;
      case (o)
         4'h0, 4'h8: res = x & y;
         4'h1, 4'h9: res = x ^ y;
         4'hC: res = x | y;
         4'hD: res = y;
         4'hE: res = x & ~y;
         4'hF: res = ~y;
         4'h4, 4'h5, 4'hB: begin
            sub = longint'(l) + longint'(r) + ((o == 4'h5) ? longint'(fc) : 0);
            res = sub[31:0];
            c   = sub[32];
            v   = (l[31] == r[31]) && (res[31] != l[31]);
         end
         4'h2, 4'h3, 4'hA: begin
            res = l - r;
            c   = r <= l;
            v   = (l[31] != r[31]) && (res[31] != l[31]);
         end
         default: begin
            sub = longint'(r) - longint'(fc) + 1;
            res = l - sub[31:0];
            c   = sub <= longint'(l);
            v   = (l[31] != r[31]) && (res[31] != l[31]);
         end
      endcase
      if (bitw) begin c = sh; v = fv; end
      we   = !tst;
      und  = tst && d == 4'hF;
      rest = !tst && s && d == 4'hF;
      upd  = tst ? (d != 4'hF) : (s && d != 4'hF);
      if (!upd) return {res, we, fn, fz, fc, fv, rest, und};
      return {res, we, res[31], res == 32'h0, c, v, rest, und};
   endfunction

   task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic [3:0] f, input logic sh, input logic s, input logic [3:0] d);
      @(negedge clk);
      op = o; a = x; b = y; {nin, zin, cin, vin} = f; shc = sh; sf = s; dst = d;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input ovec_t exp);
      ovec_t act;
      act = {result, result_we, n_out, z_out, c_out, v_out, restore_psr, undef_op};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s op=%h a=%h b=%h act=%h exp=%h", tag, op, a, b, act, exp);
      end
   endtask

   task automatic run(input string tag, input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                      input logic [3:0] f, input logic sh, input logic s, input logic [3:0] d);
      drive(o, x, y, f, sh, s, d);
      check(tag, model(o, x, y, f[3], f[2], f[1], f[0], sh, s, d));
   endtask

   // reset state: all-zero inputs give a zero AND result with write enabled
   task automatic t_reset();
      drive(4'h0, 0, 0, 4'h0, 0, 0, 4'h0);
      check("R1 reset", {32'h0, 1'b1, 4'b0000, 2'b00});
   endtask

   task automatic t_bitwise();
      drive(4'hE, 32'hFF00_FF0F, 32'h0F0F_0F0F, 4'b0001, 1'b1, 1'b1, 4'h2);
      check("R1 R5 bic", {32'hF000_F000, 1'b1, 4'b1011, 2'b00});
      drive(4'hF, 32'h0, 32'hFFFF_FFFF, 4'b1110, 1'b0, 1'b1, 4'h0);
      check("R1 R5 mvn zero", {32'h0, 1'b1, 4'b0100, 2'b00});
      run("R1 eor", 4'h1, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 4'b0000, 0, 1, 3);
      run("R1 orr", 4'hC, 32'h1234_0000, 32'h0000_5678, 4'b0001, 1, 1, 3);
      run("R1 mov", 4'hD, 32'h1, 32'h8000_0000, 4'b0000, 1, 1, 3);
   endtask

   task automatic t_add();
      drive(4'h4, 32'h7FFF_FFFF, 32'h1, 4'b0010, 0, 1, 4'h1);
      check("R2 add ovf", {32'h8000_0000, 1'b1, 4'b1001, 2'b00});
      drive(4'h5, 32'hFFFF_FFFF, 32'h0, 4'b0010, 0, 1, 4'h1);
      check("R2 adc carry", {32'h0, 1'b1, 4'b0110, 2'b00});
   endtask

   task automatic t_sub();
      drive(4'h2, 32'h0, 32'h1, 4'b0000, 0, 1, 4'h1);
      check("R3 sub borrow", {32'hFFFF_FFFF, 1'b1, 4'b1000, 2'b00});
      drive(4'h3, 32'h5, 32'h3, 4'b0000, 0, 1, 4'h1);
      check("R3 rsb", {32'hFFFF_FFFE, 1'b1, 4'b1000, 2'b00});
      drive(4'h2, 32'h8000_0000, 32'h1, 4'b0000, 0, 1, 4'h1);
      check("R3 sub ovf", {32'h7FFF_FFFF, 1'b1, 4'b0011, 2'b00});
   endtask

   task automatic t_sbc();
      drive(4'h6, 32'h5, 32'h3, 4'b0000, 0, 1, 4'h1);
      check("R4 sbc c0", {32'h1, 1'b1, 4'b0010, 2'b00});
      drive(4'h6, 32'h5, 32'hFFFF_FFFF, 4'b0000, 0, 1, 4'h1);
      check("R4 sbc wide", {32'h5, 1'b1, 4'b0000, 2'b00});
      drive(4'h7, 32'h3, 32'h5, 4'b0010, 0, 1, 4'h1);
      check("R4 rsc c1", {32'h2, 1'b1, 4'b0010, 2'b00});
   endtask

   task automatic t_noset();
      drive(4'h4, 32'hFFFF_FFFF, 32'h1, 4'b1001, 1, 0, 4'h2);
      check("R6 hold", {32'h0, 1'b1, 4'b1001, 2'b00});
      run("R6 hold logic", 4'h0, 32'h0, 32'h0, 4'b0110, 0, 0, 4'h7);
   endtask

   task automatic t_test();
      drive(4'hA, 32'h7, 32'h7, 4'b1000, 0, 0, 4'h0);
      check("R7 cmp eq", {32'h0, 1'b0, 4'b0110, 2'b00});
      drive(4'h8, 32'hF0, 32'h0F, 4'b0001, 1, 0, 4'h3);
      check("R7 tst", {32'h0, 1'b0, 4'b0111, 2'b00});
      run("R7 cmn", 4'hB, 32'h8000_0000, 32'h8000_0000, 4'b0000, 0, 0, 5);
      run("R7 teq", 4'h9, 32'h8000_0000, 32'h0, 4'b0000, 0, 1, 5);
   endtask

   task automatic t_pc();
      drive(4'h4, 32'h1, 32'h2, 4'b0101, 1, 1, 4'hF);
      check("R8 restore", {32'h3, 1'b1, 4'b0101, 2'b10});
      drive(4'h0, 32'h0, 32'h0, 4'b1010, 1, 0, 4'hF);
      check("R8 no set", {32'h0, 1'b1, 4'b1010, 2'b00});
   endtask

   task automatic t_undef();
      drive(4'hA, 32'h1, 32'h1, 4'b1001, 0, 1, 4'hF);
      check("R9 cmp pc", {32'h0, 1'b0, 4'b1001, 2'b01});
      run("R9 tst pc", 4'h8, 32'h3, 32'h1, 4'b0000, 1, 0, 4'hF);
   endtask

   task automatic t_corners();
      logic [31:0] cv [5];
      cv[0] = 32'h0; cv[1] = 32'h1; cv[2] = 32'h7FFF_FFFF; cv[3] = 32'h8000_0000; cv[4] = 32'hFFFF_FFFF;
      for (int o = 0; o < 16; o++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
               for (int k = 0; k < 2; k++)
                  run("R10 corner", 4'(o), cv[i], cv[j], {3'b000, 1'b0} | {2'b00, 1'(k), 1'(j & 1)},
                      1'(i & 1), 1'b1, 4'h0);
   endtask

   task automatic t_random();
      for (int n = 0; n < 2000; n++)
         run("R2 R3 R4 random", 4'($urandom), $urandom, $urandom, 4'($urandom), 1'($urandom),
             1'($urandom), 4'($urandom));
   endtask

   initial begin
      op = '0; a = '0; b = '0; {nin, zin, cin, vin} = '0; shc = 0; sf = 0; dst = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset();
      t_bitwise();
      t_add();
      t_sub();
      t_sbc();
      t_noset();
      t_test();
      t_pc();
      t_undef();
      t_corners();
      t_random();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule